// File: doc/BRIEF.md
# Quarter-Rate Folded FIR Engine

This block is a 16-tap real FIR filter built around only four multipliers. Samples stream in one per clock. Each multiplier serves four taps: it reads a fixed point of a delay line whose read points are four registers apart, and a two-bit phase counter walks it through four coefficients, one per clock. Over four clocks an accumulator collects four partial sums of four products each. A transfer step then copies the finished sum, cut to a fixed bit field, into an output register. The block therefore delivers one filtered value for every four input samples: its output rate is a quarter of its input rate.

The sixteen signed coefficients are loaded through a simple write port that names one entry per cycle. Entry j weights the sample that is j positions older than the newest sample in the window. The phase counter is brought out as `bank_sel`, so that a neighbouring block can align itself to the output cadence.

Top module: `fold4_fir`

## Requirements
- R1: While reset is low, and after it is released, `y_out` is 0, `out_vld` is 0 and `bank_sel` is 0. Reset also clears all sixteen coefficients to 0, so if none is written the output stays 0 whatever the samples.
- R2: `bank_sel` is 0 in cycle 0, the first cycle after reset is released. It then steps by one every clock: 0, 1, 2, 3, 0, and so on.
- R3: A cycle with `coef_we` high stores `coef_wdata` (10-bit two's complement) in the entry named by `coef_addr` (0 to 15). The write takes effect from the next cycle. Entry j multiplies the sample of lag j.
- R4: Let x(c) be the signed 10-bit sample presented on `din` in cycle c, with samples before cycle 0 taken as 0. Result g is S(g) = sum over j = 0..15 of h[j]·x(4g+2−j).
- R5: `y_out` is bits 27 down to 9 of S(g) held as a 28-bit two's complement value. This equals floor(S/512), so negative sums round toward minus infinity.
- R6: `out_vld` is high for exactly one cycle, in cycle 4g+5, which is the cycle with `bank_sel` = 1. It is low in every other cycle. `y_out` carries result g from cycle 4g+5 and holds its value while `out_vld` is low.
- R7: Each result starts from a fresh sum. Once sixteen zero samples have filled the window, the output returns to exactly 0, with no residue from earlier results.
- R8: When `coef_we` is low, values on `coef_addr` and `coef_wdata` have no effect on any later output.
- R9: The full signed range is exact: sixteen products of −512 by −512 give `y_out` = 8192.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Signed input sample, one per clock |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient entry index (tap lag) |
| coef_wdata | input | 10 | Signed coefficient value |
| bank_sel | output | 2 | Current coefficient phase |
| y_out | output | 19 | Filter result, bits 27..9 of the 28-bit sum |
| out_vld | output | 1 | One-cycle pulse when `y_out` takes a new result |

## Verification
A sample driven in cycle c enters the delay line at the end of that cycle. The accumulator finishes result g at the end of cycle 4g+3. The transfer register copies it at the end of cycle 4g+4, so `y_out` and `out_vld` show it in cycle 4g+5. The bench counts cycles from reset release and samples every output at the falling clock edge. In each cycle it checks `bank_sel` against c mod 4 and `out_vld` against the 4g+5 pattern. In pulse cycles it compares `y_out` with the sum it computes itself from the samples and coefficients it drove; in all other cycles it checks that `y_out` holds its last value.

// File: rtl/fold4_pkg.sv
package fold4_pkg;

  // Coefficient entry used by multiplier m during phase p.
  // Multiplier m reads the delay-line point at lag nph*m. During phase p
  // that point holds the sample of lag nph*m + (nph-1-p) relative to the
  // newest sample of the finished window.
  function automatic int bank_entry(input int m, input int p, input int nph);
    return nph * m + (nph - 1 - p);
  endfunction

  // Next phase value, wrapping after nph-1.
  function automatic int next_phase(input int p, input int nph);
    return (p == nph - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/fold4_phase.sv
module fold4_phase #(
  parameter int NPH = 4,
  localparam int PHW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PHW-1:0] ph,
  output logic           ph_first,
  output logic           ph_last
);
  import fold4_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= PHW'(next_phase(int'(ph), NPH));
  end

  assign ph_first = (ph == '0);
  assign ph_last  = (ph == PHW'(NPH - 1));

endmodule

// File: rtl/fold4_delay.sv
module fold4_delay #(
  parameter int DW      = 10,
  parameter int NMUL    = 4,
  parameter int SPACING = 4,
  localparam int DEPTH  = SPACING * (NMUL - 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DW-1:0]             din,
  output logic [NMUL-1:0][DW-1:0]   taps
);
  // sr[0] holds the newest registered sample
  logic [DEPTH-1:0][DW-1:0] sr;

  generate
    if (DEPTH > 1) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr[0] <= din;
      end
    end
  endgenerate

  genvar m;
  generate
    for (m = 0; m < NMUL; m++) begin : g_tap
      assign taps[m] = sr[SPACING * m];
    end
  endgenerate

endmodule

// File: rtl/fold4_coef.sv
module fold4_coef #(
  parameter int CW   = 10,
  parameter int NMUL = 4,
  parameter int NPH  = 4,
  localparam int TAPS = NMUL * NPH,
  localparam int AW   = $clog2(TAPS),
  localparam int PHW  = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [CW-1:0]           wdata,
  input  logic [PHW-1:0]          ph,
  output logic [NMUL-1:0][CW-1:0] mcoef
);
  import fold4_pkg::*;

  logic [TAPS-1:0][CW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  regs <= '0;
    else if (we) regs[waddr] <= wdata;
  end

  genvar m;
  generate
    for (m = 0; m < NMUL; m++) begin : g_sel
      logic [AW-1:0] idx;
      assign idx      = AW'(bank_entry(m, int'(ph), NPH));
      assign mcoef[m] = regs[idx];
    end
  endgenerate

endmodule

// File: rtl/fold4_mac.sv
module fold4_mac #(
  parameter int DW      = 10,
  parameter int CW      = 10,
  parameter int NMUL    = 4,
  parameter int ACCW    = 28,
  parameter int OUT_LSB = 9,
  localparam int PW     = DW + CW,
  localparam int OUT_W  = ACCW - OUT_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NMUL-1:0][DW-1:0] taps,
  input  logic [NMUL-1:0][CW-1:0] mcoef,
  input  logic                    ph_first,
  input  logic                    ph_last,
  output logic                    xfer,
  output logic [OUT_W-1:0]        y_out,
  output logic                    out_vld
);
  logic signed [PW-1:0]   prod [NMUL];
  logic signed [ACCW-1:0] psum;
  logic signed [ACCW-1:0] acc;

  genvar m;
  generate
    for (m = 0; m < NMUL; m++) begin : g_mul
      assign prod[m] = $signed(taps[m]) * $signed(mcoef[m]);
    end
  endgenerate

  always_comb begin
    psum = '0;
    for (int i = 0; i < NMUL; i++) psum = psum + ACCW'(prod[i]);
  end

  // accumulator: load on the first phase, add on the others
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (ph_first) acc <= psum;
    else               acc <= acc + psum;
  end

  // transfer strobe: set for the cycle after the last phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer <= 1'b0;
    else        xfer <= ph_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= xfer;
      if (xfer) y_out <= acc[ACCW-1:OUT_LSB];
    end
  end

endmodule

// File: rtl/fold4_fir.sv
module fold4_fir #(
  parameter int DW      = 10,
  parameter int CW      = 10,
  parameter int NMUL    = 4,
  parameter int NPH     = 4,
  parameter int ACCW    = 28,
  parameter int OUT_LSB = 9,
  localparam int TAPS   = NMUL * NPH,
  localparam int AW     = $clog2(TAPS),
  localparam int PHW    = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int OUT_W  = ACCW - OUT_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    din,
  input  logic             coef_we,
  input  logic [AW-1:0]    coef_addr,
  input  logic [CW-1:0]    coef_wdata,
  output logic [PHW-1:0]   bank_sel,
  output logic [OUT_W-1:0] y_out,
  output logic             out_vld
);
  logic                    first_w;
  logic                    last_w;
  logic                    xfer_w;
  logic [NMUL-1:0][DW-1:0] taps_w;
  logic [NMUL-1:0][CW-1:0] coef_w;

  fold4_phase #(.NPH(NPH)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (bank_sel),
    .ph_first (first_w),
    .ph_last  (last_w)
  );

  fold4_delay #(.DW(DW), .NMUL(NMUL), .SPACING(NPH)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .taps  (taps_w)
  );

  fold4_coef #(.CW(CW), .NMUL(NMUL), .NPH(NPH)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .ph    (bank_sel),
    .mcoef (coef_w)
  );

  fold4_mac #(.DW(DW), .CW(CW), .NMUL(NMUL), .ACCW(ACCW), .OUT_LSB(OUT_LSB)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .taps     (taps_w),
    .mcoef    (coef_w),
    .ph_first (first_w),
    .ph_last  (last_w),
    .xfer     (xfer_w),
    .y_out    (y_out),
    .out_vld  (out_vld)
  );

endmodule

// File: rtl/fold4_fir_chk.sv
module fold4_fir_chk #(
  parameter int NPH   = 4,
  parameter int PHW   = 2,
  parameter int OUT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PHW-1:0]   bank_sel,
  input logic [OUT_W-1:0] y_out,
  input logic             out_vld,
  input logic             xfer,
  input logic             first
);

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel == PHW'(NPH - 1)) |=> (bank_sel == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != PHW'(NPH - 1)) |=> (bank_sel == $past(bank_sel) + PHW'(1)));

  // R6
  vld_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (bank_sel == PHW'(1)));

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R6
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(y_out));

  // R4
  xfer_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> first);

  // R4
  xfer_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> out_vld);

endmodule

bind fold4_fir fold4_fir_chk #(.NPH(NPH), .PHW(PHW), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bank_sel (bank_sel),
  .y_out    (y_out),
  .out_vld  (out_vld),
  .xfer     (xfer_w),
  .first    (first_w)
);

// File: tb/sim_fold4_fir.sv
`timescale 1ns/1ps
module sim_fold4_fir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  din = '0;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_addr = '0;
  logic [9:0]  coef_wdata = '0;
  logic [1:0]  bank_sel;
  logic [18:0] y_out;
  logic        out_vld;

  fold4_fir u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .bank_sel(bank_sel), .y_out(y_out), .out_vld(out_vld)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int hist [0:1023];
  int hm [0:15];
  logic [18:0] last_y = '0;
  string cur_tag = "R4";
  logic [18:0] want_y = '0;
  bit seen_want = 1'b0;

  // vector table: write?, coef base, coef step, sample base, sample step,
  // alternate sign, sample count, lead-in cycles
  localparam int NV = 6;
  localparam int V_WR [NV] = '{0,   1,    1,  1,    1,   1};
  localparam int V_CB [NV] = '{0,   10, -200, 1, -512, 511};
  localparam int V_CS [NV] = '{0,   13,   31, 0,    0, -64};
  localparam int V_XB [NV] = '{100, 50,  300, -1, -512, 511};
  localparam int V_XS [NV] = '{7,   3,   -41, 0,    0,   0};
  localparam int V_XA [NV] = '{0,   0,     1, 0,    0,   1};
  localparam int V_N  [NV] = '{20,  24,   30, 20,  24,  17};
  localparam int V_LD [NV] = '{0,   1,     2, 3,    0,   1};

  function automatic int sx10(input int v);
    logic [9:0] t;
    t = v[9:0];
    return int'($signed(t));
  endfunction

  function automatic logic [18:0] model_y(input int g);
    longint s;
    s = 0;
    for (int j = 0; j < 16; j++) begin
      if (4 * g + 2 - j >= 0) s = s + longint'(hm[j]) * longint'(hist[4 * g + 2 - j]);
    end
    return 19'(s >>> 9);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic look();
    bit ev;
    logic [18:0] e;
    chk(bank_sel == 2'(cyc % 4), "R2", longint'(bank_sel), longint'(cyc % 4));
    ev = (cyc >= 5) && (cyc % 4 == 1);
    chk(out_vld == ev, "R6", longint'(out_vld), longint'(ev));
    if (ev) begin
      e = model_y((cyc - 5) / 4);
      chk(y_out == e, cur_tag, longint'($signed(y_out)), longint'($signed(e)));
      if (y_out == want_y) seen_want = 1'b1;
      last_y = y_out;
    end else begin
      chk(y_out == last_y, "R6", longint'($signed(y_out)), longint'($signed(last_y)));
    end
  endtask

  // one cycle: check outputs of cycle cyc, drive inputs for it, advance
  task automatic tick(input int d, input bit we, input int a, input int w);
    look();
    din        = 10'(d);
    coef_we    = we;
    coef_addr  = 4'(a);
    coef_wdata = 10'(w);
    hist[cyc]  = sx10(d);
    if (we) hm[a % 16] = sx10(w);
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0; coef_we = 1'b0;
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk(y_out == '0, "R1", longint'(y_out), 0);
    chk(out_vld == 1'b0, "R1", longint'(out_vld), 0);
    chk(bank_sel == '0, "R1", longint'(bank_sel), 0);
    for (int i = 0; i < 1024; i++) hist[i] = 0;
    for (int j = 0; j < 16; j++) hm[j] = 0;
    last_y = '0;
    cyc = 0;
    seen_want = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      do_reset();
      case (v)
        0: cur_tag = "R1";
        1: cur_tag = "R3";
        2: cur_tag = "R8";
        3: cur_tag = "R5";
        4: cur_tag = "R9";
        default: cur_tag = "R4";
      endcase
      want_y = (v == 3) ? 19'h7FFFF : 19'd8192;
      for (int j = 0; j < 16; j++)
        tick(0, V_WR[v] != 0, j, V_CB[v] + V_CS[v] * j);
      for (int k = 0; k < V_LD[v]; k++) tick(0, 1'b0, k * 5 + 3, 300 - 77 * k);
      for (int k = 0; k < V_N[v]; k++) begin
        int x;
        x = sx10(V_XB[v] + V_XS[v] * k);
        if (V_XA[v] != 0 && (k % 2) == 1) x = -x;
        // R8: address and data move while the write strobe is low
        tick(x, 1'b0, (k * 7 + 1) % 16, 123 + 91 * k);
      end
      for (int k = 0; k < 28; k++) tick(0, 1'b0, k % 16, -k * 17);
      // R7: output back to zero after the window is flushed
      chk(y_out == '0, "R7", longint'($signed(y_out)), 0);
      if (v == 3) chk(seen_want, "R5", longint'(seen_want), 1);
      if (v == 4) chk(seen_want, "R9", longint'(seen_want), 1);
    end

    // R3: single coefficient at lag 5, impulse of 400 in cycle 17 -> result 5 = 78
    do_reset();
    cur_tag = "R3";
    want_y = 19'd78;
    tick(0, 1'b1, 5, 100);
    while (cyc < 17) tick(0, 1'b0, 0, 0);
    tick(400, 1'b0, 0, 0);
    while (cyc < 26) tick(0, 1'b0, 0, 0);
    chk(seen_want, "R3", longint'(seen_want), 1);
    // the result appears exactly in cycle 25 and then holds
    chk(y_out == 19'd78, "R3", longint'(y_out), 78);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule